// File: doc/BRIEF.md
# Dual-Register Input Change Latch

The block watches eight digital inputs and catches the first level change on each one. Every input owns a pair of bits: a "new" bit that takes the changed level and then holds it, and an "old" bit that keeps the level from before the change. When any unmasked input changes, the block raises a change-indication output and records the event in a status word. Further toggles on an input that has already been caught are ignored until the host collects the new register.

A host reads through a parallel port: a one-cycle strobe and a 2-bit address pick the old register, the new register, the status word or the control register. The data is registered and appears on the cycle after the strobe. Reading the new register copies every new bit into its old bit and re-arms capture. Reading the status word clears it and drops the change indication. Seven outside event sources can each set one status bit with a single-cycle pulse. Through the control register the host can mask the upper four inputs and can enable a reset-request pulse on input change.

Top module: `chl_input_latch`

## Requirements
- R1: After reset the old, new, status and control registers and rd_data are all zero, chg_ind and rst_out are low, and every input is armed.
- R2: A level change on an armed, unmasked input passes a two-flop synchronizer, so it shows in the new register, status bit 0 and chg_ind after the third rising clock edge from the change. That input is then disarmed.
- R3: While an input is disarmed, further level changes on it leave its new and old bits untouched.
- R4: A read at address 0 (old register) returns the old bits and changes no latch.
- R5: A read at address 1 returns the new register and copies every unmasked new bit into its old bit. Every input is re-armed, and a live level that differs from the held new bit is caught on the following cycle.
- R6: Control bits 3:0 mask inputs 4 to 7 in that order (bit k masks input 4+k). The old and new bits of a masked input follow its synchronized level on every cycle, and a masked input never raises chg_ind or rst_out.
- R7: When control bit 4 is set, each cycle that catches an input change gives a one-cycle high on rst_out, at the same edge that updates the new register.
- R8: A read at address 2 returns the status word as it stood before the read, then clears it and lowers chg_ind.
- R9: A pulse on ext_set[k] sets status bit k+1 and chg_ind. A set wins over a status read in the same cycle.
- R10: rd_data is loaded at the clock edge that samples rd_stb and keeps its value when no strobe is given. Address 3 returns the control register in bits 4:0 with the upper bits zero. A control write (ctl_wr with ctl_wdata) takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Monitored digital inputs (asynchronous) |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | 2 | Read select: 0 old, 1 new, 2 status, 3 control |
| rd_data | output | 8 | Registered read data |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control value: bits 3:0 mask inputs 4..7, bit 4 enables rst_out |
| ext_set | input | 7 | Event pulses from outside sources, one per status bit 7:1 |
| chg_ind | output | 1 | Change indication |
| rst_out | output | 1 | Reset-request pulse on unmasked input change |

## Verification
The hardest case to reach from the ports is a disarmed input whose live level has already moved on when the new register is read. Re-arming must then catch the difference one cycle later, while the old register takes the value that was held. The stimulus toggles an input back before collecting the new register, then reads twice. A second hard case is an outside set pulse that lands in the very cycle of a status read. The bench drives both in the same negedge slot, and a long random phase with sparse reads and mask changes covers the collisions that directed tests miss.

// File: rtl/chl_pkg.sv
package chl_pkg;

  typedef enum logic [1:0] {
    ADR_OLD  = 2'd0,
    ADR_NEW  = 2'd1,
    ADR_STAT = 2'd2,
    ADR_CTL  = 2'd3
  } rd_sel_e;

  // An armed, unmasked bit catches when its live level leaves the held value.
  function automatic logic bit_catch(input logic armed, input logic masked,
                                     input logic live, input logic held);
    return armed & ~masked & (live ^ held);
  endfunction

  // Sticky status bit update: clear on read, a set in the same cycle wins.
  function automatic logic sticky_next(input logic cur, input logic clr,
                                       input logic set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/chl_sync.sv
module chl_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[b] <= 1'b0;
        stage2[b] <= 1'b0;
      end else begin
        stage1[b] <= async_in[b];
        stage2[b] <= stage1[b];
      end
    end
  end

  assign sync_out = stage2;

endmodule

// File: rtl/chl_bit_cell.sv
module chl_bit_cell
  import chl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic masked,
  input  logic rd_new,
  output logic new_o,
  output logic old_o,
  output logic evt_o
);

  logic new_q;
  logic old_q;
  logic armed_q;
  logic catch_w;

  assign catch_w = bit_catch(armed_q, masked, live, new_q) & ~rd_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q   <= 1'b0;
      old_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (masked) begin
      new_q   <= live;
      old_q   <= live;
      armed_q <= 1'b1;
    end else if (rd_new) begin
      old_q   <= new_q;
      armed_q <= 1'b1;
    end else if (catch_w) begin
      new_q   <= live;
      armed_q <= 1'b0;
    end
  end

  assign new_o = new_q;
  assign old_o = old_q;
  assign evt_o = catch_w;

endmodule

// File: rtl/chl_status.sv
module chl_status
  import chl_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic          clr,
  output logic [SW-1:0] stat_o,
  output logic          chg_o
);

  logic [SW-1:0] stat_q;
  logic          chg_q;

  for (genvar s = 0; s < SW; s++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[s] <= 1'b0;
      else        stat_q[s] <= sticky_next(stat_q[s], clr, set_vec[s]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= sticky_next(chg_q, clr, |set_vec);
  end

  assign stat_o = stat_q;
  assign chg_o  = chg_q;

endmodule

// File: rtl/chl_input_latch.sv
module chl_input_latch
  import chl_pkg::*;
#(
  parameter int NIN   = 8,
  parameter int NMASK = 4,
  parameter int NEXT  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIN-1:0]   din,
  input  logic             rd_stb,
  input  logic [1:0]       rd_addr,
  output logic [NIN-1:0]   rd_data,
  input  logic             ctl_wr,
  input  logic [NMASK:0]   ctl_wdata,
  input  logic [NEXT-1:0]  ext_set,
  output logic             chg_ind,
  output logic             rst_out
);

  localparam int MASK_LO = NIN - NMASK;
  localparam int CTL_W   = NMASK + 1;
  localparam int SW      = NEXT + 1;

  logic [NIN-1:0]   live_w;
  logic [NIN-1:0]   mask_ext;
  logic [NIN-1:0]   new_q;
  logic [NIN-1:0]   old_q;
  logic [NIN-1:0]   evt;
  logic [CTL_W-1:0] ctl_q;
  logic [SW-1:0]    stat_q;
  logic [SW-1:0]    stat_set;
  logic             rp_en;
  logic             rd_new;
  logic             rd_stat;
  logic             any_evt;
  logic [NIN-1:0]   rd_nxt;
  logic             rst_q;

  chl_sync #(.W(NIN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (din),
    .sync_out (live_w)
  );

  // Control register: mask bits for the upper inputs, then reset enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_wdata;
  end

  assign rp_en = ctl_q[NMASK];

  for (genvar i = 0; i < NIN; i++) begin : g_mask
    if (i >= MASK_LO) begin : g_maskable
      assign mask_ext[i] = ctl_q[i-MASK_LO];
    end else begin : g_fixed
      assign mask_ext[i] = 1'b0;
    end
  end

  assign rd_new  = rd_stb && (rd_addr == ADR_NEW);
  assign rd_stat = rd_stb && (rd_addr == ADR_STAT);

  for (genvar i = 0; i < NIN; i++) begin : g_cell
    chl_bit_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .live   (live_w[i]),
      .masked (mask_ext[i]),
      .rd_new (rd_new),
      .new_o  (new_q[i]),
      .old_o  (old_q[i]),
      .evt_o  (evt[i])
    );
  end

  assign any_evt  = |evt;
  assign stat_set = {ext_set, any_evt};

  chl_status #(.SW(SW)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (stat_set),
    .clr     (rd_stat),
    .stat_o  (stat_q),
    .chg_o   (chg_ind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= any_evt & rp_en;
  end

  assign rst_out = rst_q;

  always_comb begin
    rd_nxt = '0;
    unique case (rd_addr)
      ADR_OLD:  rd_nxt = old_q;
      ADR_NEW:  rd_nxt = new_q;
      ADR_STAT: rd_nxt[SW-1:0] = stat_q;
      ADR_CTL:  rd_nxt[CTL_W-1:0] = ctl_q;
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= rd_nxt;
  end

endmodule

// File: rtl/chl_checker.sv
module chl_checker #(
  parameter int NIN  = 8,
  parameter int NEXT = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_stb,
  input logic [1:0]      rd_addr,
  input logic [NEXT-1:0] ext_set,
  input logic [NIN-1:0]  new_q,
  input logic [NIN-1:0]  old_q,
  input logic [NIN-1:0]  mask_ext,
  input logic [NIN-1:0]  evt,
  input logic [NEXT:0]   stat_q,
  input logic            chg_ind,
  input logic            rst_out,
  input logic [NIN-1:0]  rd_data
);

  logic rd_new_c;
  logic rd_stat_c;
  assign rd_new_c  = rd_stb && (rd_addr == 2'd1);
  assign rd_stat_c = rd_stb && (rd_addr == 2'd2);

  a_r2_event_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (chg_ind && stat_q[0]));

  a_r4_old_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_new_c |=> ($stable(mask_ext) -> $stable(old_q & ~mask_ext)));

  a_r5_copy_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_new_c |=> ((old_q & ~$past(mask_ext)) == ($past(new_q) & ~$past(mask_ext))));

  a_r6_masked_track: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((new_q ^ old_q) & $past(mask_ext)) == '0));

  a_r7_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> $past(|evt));

  a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_c && !(|ext_set) && !(|evt)) |=> (stat_q == '0 && !chg_ind));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_set) |=> (chg_ind && ((stat_q[NEXT:1] & $past(ext_set)) == $past(ext_set))));

  a_r10_new_readback: assert property (@(posedge clk) disable iff (!rst_n)
    rd_new_c |=> (rd_data == $past(new_q)));

  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

endmodule

bind chl_input_latch chl_checker #(.NIN(NIN), .NEXT(NEXT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_stb   (rd_stb),
  .rd_addr  (rd_addr),
  .ext_set  (ext_set),
  .new_q    (new_q),
  .old_q    (old_q),
  .mask_ext (mask_ext),
  .evt      (evt),
  .stat_q   (stat_q),
  .chg_ind  (chg_ind),
  .rst_out  (rst_out),
  .rd_data  (rd_data)
);

// File: tb/test_chl_input_latch.sv
module test_chl_input_latch;

  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = '0;
  logic       rd_stb = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [6:0] ext_set = '0;
  logic       chg_ind;
  logic       rst_out;

  int checks = 0;
  int errors = 0;
  int rst_cnt = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  chl_input_latch i_chl_input_latch (
    .clk(clk), .rst_n(rst_n), .din(din), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ext_set(ext_set), .chg_ind(chg_ind), .rst_out(rst_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  bit [7:0] m_s1, m_s2, m_new, m_old, m_arm, m_rd, m_stat;
  bit [4:0] m_ctl;
  bit       m_chg, m_rst;
  bit [7:0] t_new, t_old, t_arm, t_mask;
  bit       t_ev, t_clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_new = 0; m_old = 0; m_arm = 8'hff;
      m_rd = 0; m_stat = 0; m_ctl = 0; m_chg = 0; m_rst = 0;
    end else begin
      t_mask = {m_ctl[3:0], 4'b0000};
      t_new = m_new; t_old = m_old; t_arm = m_arm; t_ev = 0;
      for (int i = 0; i < 8; i++) begin
        if (t_mask[i]) begin
          t_new[i] = m_s2[i]; t_old[i] = m_s2[i]; t_arm[i] = 1;
        end else if (rd_stb && rd_addr == 2'd1) begin
          t_old[i] = m_new[i]; t_arm[i] = 1;
        end else if (m_arm[i] && (m_s2[i] != m_new[i])) begin
          t_new[i] = m_s2[i]; t_arm[i] = 0; t_ev = 1;
        end
      end
      if (rd_stb) begin
        case (rd_addr)
          2'd0: m_rd = m_old;
          2'd1: m_rd = m_new;
          2'd2: m_rd = m_stat;
          default: m_rd = {3'b000, m_ctl};
        endcase
      end
      t_clr = rd_stb && rd_addr == 2'd2;
      m_stat = (t_clr ? 8'h00 : m_stat) | {ext_set, t_ev};
      m_chg  = (t_clr ? 1'b0 : m_chg) | t_ev | (|ext_set);
      m_rst  = t_ev & m_ctl[4];
      if (ctl_wr) m_ctl = ctl_wdata;
      m_new = t_new; m_old = t_old; m_arm = t_arm;
      m_s2 = m_s1; m_s1 = din;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 rd_data vs model", rd_data, m_rd);
      chk("R2 chg_ind vs model", chg_ind, m_chg);
      chk("R7 rst_out vs model", rst_out, m_rst);
      if (rst_out) rst_cnt++;
    end
  end

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_stb = 1; rd_addr = a;
    @(negedge clk);
    rd_stb = 0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 chg_ind", chg_ind, 0);
    chk("R1 rst_out", rst_out, 0);
    rd(2'd0, d); chk("R1 old", d, 8'h00);
    rd(2'd1, d); chk("R1 new", d, 8'h00);
    rd(2'd2, d); chk("R1 status", d, 8'h00);
    rd(2'd3, d); chk("R1 control", d, 8'h00);

    // R2/R3/R4/R5: capture, ignore while disarmed, collect, recapture
    din = 8'h05; idle(4);
    chk("R2 chg raised", chg_ind, 1);
    rd(2'd0, d); chk("R4 old unchanged", d, 8'h00);
    din = 8'h04; idle(4);
    rd(2'd1, d); chk("R3 disarmed bit held", d, 8'h05);
    idle(4);
    rd(2'd0, d); chk("R5 old got new", d, 8'h05);
    rd(2'd1, d); chk("R5 recapture after rearm", d, 8'h04);
    rd(2'd0, d); chk("R5 old after second read", d, 8'h04);
    rd(2'd2, d); chk("R8 status read", d, 8'h01);
    chk("R8 chg cleared", chg_ind, 0);

    // R6/R7: mask input 4, enable reset pulse
    ctl_wr = 1; ctl_wdata = 5'b10001; @(negedge clk); ctl_wr = 0;
    r0 = rst_cnt;
    din = 8'h14; idle(4);
    chk("R6 masked no chg", chg_ind, 0);
    chk("R6 masked no pulse", rst_cnt - r0, 0);
    rd(2'd1, d); chk("R6 masked new tracks", d, 8'h14);
    rd(2'd0, d); chk("R6 masked old tracks", d, 8'h14);
    din = 8'h34; idle(4);
    chk("R7 one pulse", rst_cnt - r0, 1);
    rd(2'd1, d); chk("R7 unmasked capture", d, 8'h34);
    rd(2'd2, d); chk("R8 status after event", d, 8'h01);

    // R9: set pulse coincides with status read
    ext_set = 7'b0000100; rd_stb = 1; rd_addr = 2'd2;
    @(negedge clk);
    ext_set = 0; rd_stb = 0;
    chk("R9 read sees prior status", rd_data, 8'h00);
    chk("R9 chg kept", chg_ind, 1);
    rd(2'd2, d); chk("R9 set survived", d, 8'h08);

    // R10: control readback
    rd(2'd3, d); chk("R10 control readback", d, 8'h11);

    // Random phase compared against the model every cycle
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 6 == 0) din = din ^ (8'h01 << ($urandom % 8));
      rd_stb = ($urandom % 4 == 0);
      rd_addr = 2'($urandom % 4);
      ext_set = ($urandom % 16 == 0) ? 7'(1 << ($urandom % 7)) : 7'h00;
      ctl_wr = ($urandom % 50 == 0);
      ctl_wdata = 5'($urandom);
      @(negedge clk);
    end
    rd_stb = 0; ext_set = 0; ctl_wr = 0;
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PER * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule